// File: doc/BRIEF.md
# Indexed Interrupt Redirection Router

This block routes the external interrupt lines of a small multiprocessor system to processors. Software reaches every setting through a two-word window. It first writes a register number to the select word, and the data word then reads or writes the register that number names. Behind the window sit three things: a unit identifier, a read-only capability word, and one routing entry per input line. A routing entry has a low word and a high word. The low word holds the enable mask, the trigger mode, the polarity, the destination mode and the vector. The high word holds the target processor identifier.

Each unmasked line is conditioned by its polarity and trigger mode. An edge-mode line is latched as pending when its input becomes asserted. A level-mode line requests delivery for as long as it is asserted, but only while its in-service flag is clear. The flag is set when the line is delivered and cleared by an end-of-interrupt pulse that carries the same vector. Pending requests are served lowest line number first. Each delivery goes into a single registered message slot that presents vector, destination and destination mode on a valid/ready output.

Top module: `irq_redirect_router`

## Requirements
- R1: After reset, every routing low word reads 0x00010000 (masked, edge, active-high, vector 0), every high word reads 0, and no message is offered.
- R2: A write to byte offset 0x00 loads the 8-bit register number, which reads back at offset 0x00. A read or write at byte offset 0x10 then accesses the register that number selects.
- R3: Register 0x00 holds the unit identifier in bits 31:24. It resets to the UNIT_ID_RST parameter (default 0x02), is writable, and its other bits read 0.
- R4: Register 0x01 reads 0x00170011 with the default 24 lines: line count minus one in bits 23:16 and the code 0x11 in bits 7:0. Writes to it are ignored.
- R5: Line n has its low word at register 0x10+2n and its high word at 0x11+2n. The low word fields are: bit 16 mask, bit 15 level mode, bit 14 in-service (read-only), bit 13 active-low, bit 11 logical destination, bits 7:0 vector. The high word holds the destination in bits 31:24. All other bits read 0.
- R6: An unmasked edge-mode line produces exactly one message when it becomes asserted, carrying its vector, its destination and its destination-mode bit on msg_logical. Holding the input asserted produces nothing more.
- R7: With the active-low bit set, the low input value counts as asserted: a falling input triggers an edge-mode line.
- R8: A delivered level-mode line sets its in-service bit and is not delivered again until eoi_valid pulses with a matching eoi_vector. If the input is still asserted at that point, it is delivered again.
- R9: A masked line never produces a message, and an edge seen while masked is discarded, so unmasking afterwards produces nothing.
- R10: When several lines request at once, messages leave in ascending line order.
- R11: While msg_valid is high and msg_ready is low, msg_valid stays high and the message fields hold.
- R12: Reading an unimplemented register number (0x02 to 0x0F, 0x40 and above) returns 0. Writing one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the window |
| bus_addr | input | 8 | Byte offset: 0x00 select word, 0x10 data word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the offset on bus_addr (combinational) |
| irq_in | input | NUM_LINES | External interrupt lines |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | Delivery message offered |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Vector of the message |
| msg_dest | output | 8 | Destination processor identifier |
| msg_logical | output | 1 | Destination mode: 1 logical, 0 physical |

## Verification
A wrong in-service flag shows up in one of two ways. A level line is delivered again with no end-of-interrupt in between, or it stays silent after a matching end-of-interrupt. Both become visible at msg_valid within two cycles. A lost or stuck pending bit shows as a missing or duplicated message on the edge that caused it. A broken priority pick shows directly as messages in the wrong order. A stale select register or a bad field decode shows on the very next read of the data word.

// File: rtl/irr_pkg.sv
package irr_pkg;
    localparam logic [7:0] OFS_INDEX = 8'h00;
    localparam logic [7:0] OFS_DATA  = 8'h10;
    localparam logic [7:0] IDX_ID    = 8'h00;
    localparam logic [7:0] IDX_VER   = 8'h01;
    localparam logic [7:0] IDX_TAB   = 8'h10;

    localparam int B_MASK    = 16;
    localparam int B_LEVEL   = 15;
    localparam int B_RIRR    = 14;
    localparam int B_ACTLOW  = 13;
    localparam int B_LOGICAL = 11;

    typedef struct packed {
        logic       mask;
        logic       level;
        logic       act_low;
        logic       logical;
        logic [7:0] vector;
        logic [7:0] dest;
    } route_cfg_t;

    localparam route_cfg_t CFG_RESET = '{mask: 1'b1, default: '0};
endpackage

// File: rtl/irr_regfile.sv
module irr_regfile import irr_pkg::*; #(
    parameter int         NUM_LINES    = 24,
    parameter logic [7:0] UNIT_ID_RST  = 8'h02,
    parameter logic [7:0] VERSION_CODE = 8'h11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic [7:0]                   bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    input  logic [NUM_LINES-1:0]         rirr_i,
    output route_cfg_t [NUM_LINES-1:0]   cfg_o
);
    localparam int LAST_IDX = int'(IDX_TAB) + 2 * NUM_LINES - 1;

    typedef struct packed {
        logic [7:0]                 index;
        logic [7:0]                 uid;
        route_cfg_t [NUM_LINES-1:0] cfg;
    } win_state_t;

    win_state_t s_q, s_d;
    logic       in_table;
    logic [7:0] idx_off;
    logic       unused_wdata;

    assign unused_wdata = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12], bus_wdata[10:8]};

    function automatic logic [31:0] pack_low(input route_cfg_t c, input logic remote);
        logic [31:0] w;
        w            = '0;
        w[B_MASK]    = c.mask;
        w[B_LEVEL]   = c.level;
        w[B_RIRR]    = remote;
        w[B_ACTLOW]  = c.act_low;
        w[B_LOGICAL] = c.logical;
        w[7:0]       = c.vector;
        return w;
    endfunction

    always_comb begin
        idx_off  = s_q.index - IDX_TAB;
        in_table = (s_q.index >= IDX_TAB) && (s_q.index <= 8'(LAST_IDX));

        bus_rdata = '0;
        if (bus_addr == OFS_INDEX) begin
            bus_rdata = {24'b0, s_q.index};
        end else if (bus_addr == OFS_DATA) begin
            if (s_q.index == IDX_ID) begin
                bus_rdata = {s_q.uid, 24'b0};
            end else if (s_q.index == IDX_VER) begin
                bus_rdata = {8'b0, 8'(NUM_LINES - 1), 8'b0, VERSION_CODE};
            end else begin
                for (int k = 0; k < NUM_LINES; k++) begin
                    if (in_table && idx_off[7:1] == 7'(k)) begin
                        bus_rdata = s_q.index[0] ? {s_q.cfg[k].dest, 24'b0}
                                                 : pack_low(s_q.cfg[k], rirr_i[k]);
                    end
                end
            end
        end

        s_d = s_q;
        if (bus_wr) begin
            if (bus_addr == OFS_INDEX) begin
                s_d.index = bus_wdata[7:0];
            end else if (bus_addr == OFS_DATA) begin
                if (s_q.index == IDX_ID) s_d.uid = bus_wdata[31:24];
                for (int k = 0; k < NUM_LINES; k++) begin
                    if (in_table && idx_off[7:1] == 7'(k)) begin
                        if (s_q.index[0]) begin
                            s_d.cfg[k].dest = bus_wdata[31:24];
                        end else begin
                            s_d.cfg[k].mask    = bus_wdata[B_MASK];
                            s_d.cfg[k].level   = bus_wdata[B_LEVEL];
                            s_d.cfg[k].act_low = bus_wdata[B_ACTLOW];
                            s_d.cfg[k].logical = bus_wdata[B_LOGICAL];
                            s_d.cfg[k].vector  = bus_wdata[7:0];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.index <= '0;
            s_q.uid   <= UNIT_ID_RST;
            for (int k = 0; k < NUM_LINES; k++) s_q.cfg[k] <= CFG_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o = s_q.cfg;

    // R2: the select word changes only through a write at offset 0x00
    a_r2_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_INDEX) |=> $stable(s_q.index));
endmodule

// File: rtl/irr_line.sv
module irr_line import irr_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_i,
    input  route_cfg_t cfg_i,
    input  logic       take_i,
    input  logic       eoi_valid_i,
    input  logic [7:0] eoi_vector_i,
    output logic       req_o,
    output logic       rirr_o
);
    typedef struct packed {
        logic prev;
        logic pending;
        logic rirr;
    } line_state_t;

    line_state_t s_q, s_d;
    logic asserted, rise, eoi_hit;
    logic unused_cfg;

    assign unused_cfg = ^{cfg_i.dest, cfg_i.logical};

    always_comb begin
        asserted = irq_i ^ cfg_i.act_low;
        rise     = asserted & ~s_q.prev;
        eoi_hit  = eoi_valid_i && (eoi_vector_i == cfg_i.vector);

        s_d.prev = asserted;
        if (cfg_i.mask || cfg_i.level) s_d.pending = 1'b0;
        else                           s_d.pending = (s_q.pending & ~take_i) | rise;
        s_d.rirr = cfg_i.level & ((s_q.rirr & ~eoi_hit) | take_i);

        if (cfg_i.mask)       req_o = 1'b0;
        else if (cfg_i.level) req_o = asserted & ~s_q.rirr;
        else                  req_o = s_q.pending;
        rirr_o = s_q.rirr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: delivering a level line marks it in service
    a_r8_take_sets_rirr: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && cfg_i.level) |=> rirr_o);

    // R9: masking discards any latched edge
    a_r9_mask_drops_edge: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.mask |=> !s_q.pending);

    // R6: a latched edge survives until it is delivered
    a_r6_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.mask && !cfg_i.level && s_q.pending && !take_i) |=> s_q.pending);
endmodule

// File: rtl/irr_pick.sv
module irr_pick #(
    parameter int N = 24
) (
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [N-1:0] grant_o
);
    always_comb begin
        any_o   = |req_i;
        grant_o = req_i & (~req_i + N'(1));
    end
endmodule

// File: rtl/irq_redirect_router.sv
module irq_redirect_router import irr_pkg::*; #(
    parameter int         NUM_LINES    = 24,
    parameter logic [7:0] UNIT_ID_RST  = 8'h02,
    parameter logic [7:0] VERSION_CODE = 8'h11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 eoi_valid,
    input  logic [7:0]           eoi_vector,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [7:0]           msg_vector,
    output logic [7:0]           msg_dest,
    output logic                 msg_logical
);
    typedef struct packed {
        logic       valid;
        logic [7:0] vector;
        logic [7:0] dest;
        logic       logical;
    } slot_t;

    route_cfg_t [NUM_LINES-1:0] cfg_all;
    logic [NUM_LINES-1:0]       req_all, rirr_all, grant, take;
    logic                       any_req, load;
    slot_t                      slot_q, slot_d;

    irr_regfile #(
        .NUM_LINES   (NUM_LINES),
        .UNIT_ID_RST (UNIT_ID_RST),
        .VERSION_CODE(VERSION_CODE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .rirr_i   (rirr_all),
        .cfg_o    (cfg_all)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irr_line u_line (
            .clk         (clk),
            .rst_n       (rst_n),
            .irq_i       (irq_in[g]),
            .cfg_i       (cfg_all[g]),
            .take_i      (take[g]),
            .eoi_valid_i (eoi_valid),
            .eoi_vector_i(eoi_vector),
            .req_o       (req_all[g]),
            .rirr_o      (rirr_all[g])
        );
    end

    irr_pick #(.N(NUM_LINES)) u_pick (
        .req_i  (req_all),
        .any_o  (any_req),
        .grant_o(grant)
    );

    always_comb begin
        load   = any_req && (!slot_q.valid || msg_ready);
        take   = load ? grant : '0;
        slot_d = slot_q;
        if (load) begin
            slot_d.valid = 1'b1;
            for (int k = 0; k < NUM_LINES; k++) begin
                if (grant[k]) begin
                    slot_d.vector  = cfg_all[k].vector;
                    slot_d.dest    = cfg_all[k].dest;
                    slot_d.logical = cfg_all[k].logical;
                end
            end
        end else if (msg_ready) begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign msg_valid   = slot_q.valid;
    assign msg_vector  = slot_q.vector;
    assign msg_dest    = slot_q.dest;
    assign msg_logical = slot_q.logical;

    // R10: at most one line is granted per cycle
    a_r10_take_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));

    // R10: no lower-numbered line is requesting when a grant is made
    a_r10_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (((take - NUM_LINES'(1)) & req_all) == '0));

    // R11: an offered message holds under backpressure
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
                                       && $stable(msg_dest) && $stable(msg_logical)));
endmodule

// File: tb/tb_irq_redirect_router.sv
`timescale 1ns/1ps
module tb_irq_redirect_router;
    localparam int N = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = 8'h00;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic         eoi_valid = 1'b0;
    logic [7:0]   eoi_vector = 8'h00;
    logic         msg_valid;
    logic         msg_ready = 1'b0;
    logic [7:0]   msg_vector;
    logic [7:0]   msg_dest;
    logic         msg_logical;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    irq_redirect_router dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest),
        .msg_logical(msg_logical)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
        bus_write(8'h00, {24'b0, idx});
        bus_write(8'h10, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
        bus_write(8'h00, {24'b0, idx});
        @(negedge clk);
        bus_addr = 8'h10;
        #1 d = bus_rdata;
        bus_addr = 8'h00;
    endtask

    task automatic pop_expect(input string req, input logic [7:0] vec,
                              input logic [7:0] dst, input logic lg);
        int waited = 0;
        @(negedge clk);
        while (!msg_valid && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check(req, "message", {7'b0, msg_valid, 7'b0, msg_logical, msg_dest, msg_vector},
              {7'b0, 1'b1, 7'b0, lg, dst, vec});
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_quiet(input string req, input int n);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(req, "no message", {31'b0, seen}, 32'h0);
    endtask

    task automatic pulse_eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1", "msg_valid after reset", {31'b0, msg_valid}, 32'h0);
        reg_read(8'h10, d);  check("R1", "line0 low", d, 32'h0001_0000);
        reg_read(8'h3E, d);  check("R1", "line23 low", d, 32'h0001_0000);
        reg_read(8'h3F, d);  check("R1", "line23 high", d, 32'h0);
    endtask

    task automatic t_id_version();
        logic [31:0] d;
        bus_write(8'h00, 32'hFFFF_FF37);
        @(negedge clk); bus_addr = 8'h00; #1 d = bus_rdata;
        check("R2", "select word readback", d, 32'h37);
        reg_read(8'h00, d);  check("R3", "id reset", d, 32'h0200_0000);
        reg_write(8'h00, 32'hAB12_3456);
        reg_read(8'h00, d);  check("R3", "id written", d, 32'hAB00_0000);
        reg_read(8'h01, d);  check("R4", "version", d, 32'h0017_0011);
        reg_write(8'h01, 32'hFFFF_FFFF);
        reg_read(8'h01, d);  check("R4", "version after write", d, 32'h0017_0011);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        reg_write(8'h1A, 32'hFFFF_FFFF);
        reg_read(8'h1A, d);  check("R5", "line5 low all ones", d, 32'h0001_A8FF);
        reg_write(8'h1B, 32'hFFFF_FFFF);
        reg_read(8'h1B, d);  check("R5", "line5 high all ones", d, 32'hFF00_0000);
        reg_write(8'h1A, 32'h0001_0000);
        reg_write(8'h1B, 32'h0);
    endtask

    task automatic t_edge();
        reg_write(8'h16, 32'h0000_0041);
        reg_write(8'h17, 32'h0300_0000);
        @(negedge clk); irq_in[3] = 1'b1;
        pop_expect("R6", 8'h41, 8'h03, 1'b0);
        expect_quiet("R6", 10);
        @(negedge clk); irq_in[3] = 1'b0;
        reg_write(8'h18, 32'h0000_0842);
        reg_write(8'h19, 32'h8000_0000);
        @(negedge clk); irq_in[4] = 1'b1;
        @(negedge clk); irq_in[4] = 1'b0;
        pop_expect("R6", 8'h42, 8'h80, 1'b1);
    endtask

    task automatic t_active_low();
        @(negedge clk); irq_in[6] = 1'b1;
        reg_write(8'h1D, 32'h0100_0000);
        reg_write(8'h1C, 32'h0000_2046);
        expect_quiet("R7", 5);
        @(negedge clk); irq_in[6] = 1'b0;
        pop_expect("R7", 8'h46, 8'h01, 1'b0);
        @(negedge clk); irq_in[6] = 1'b1;
        expect_quiet("R7", 6);
    endtask

    task automatic t_level();
        logic [31:0] d;
        reg_write(8'h1F, 32'h0200_0000);
        reg_write(8'h1E, 32'h0000_8057);
        @(negedge clk); irq_in[7] = 1'b1;
        pop_expect("R8", 8'h57, 8'h02, 1'b0);
        reg_read(8'h1E, d);  check("R8", "in-service set", d, 32'h0000_C057);
        expect_quiet("R8", 10);
        pulse_eoi(8'h99);
        expect_quiet("R8", 4);
        pulse_eoi(8'h57);
        pop_expect("R8", 8'h57, 8'h02, 1'b0);
        @(negedge clk); irq_in[7] = 1'b0;
        pulse_eoi(8'h57);
        reg_read(8'h1E, d);  check("R8", "in-service cleared", d, 32'h0000_8057);
        expect_quiet("R8", 5);
    endtask

    task automatic t_mask();
        reg_write(8'h22, 32'h0001_0059);
        @(negedge clk); irq_in[9] = 1'b1;
        @(negedge clk); irq_in[9] = 1'b0;
        expect_quiet("R9", 4);
        reg_write(8'h22, 32'h0000_0059);
        expect_quiet("R9", 6);
        reg_write(8'h24, 32'h0001_805A);
        @(negedge clk); irq_in[10] = 1'b1;
        expect_quiet("R9", 8);
        @(negedge clk); irq_in[10] = 1'b0;
    endtask

    task automatic t_order();
        reg_write(8'h14, 32'h0000_0062);
        reg_write(8'h28, 32'h0000_006C);
        reg_write(8'h38, 32'h0000_0074);
        @(negedge clk); irq_in[2] = 1'b1; irq_in[12] = 1'b1; irq_in[20] = 1'b1;
        pop_expect("R10", 8'h62, 8'h00, 1'b0);
        pop_expect("R10", 8'h6C, 8'h00, 1'b0);
        pop_expect("R10", 8'h74, 8'h00, 1'b0);
        @(negedge clk); irq_in[2] = 1'b0; irq_in[12] = 1'b0; irq_in[20] = 1'b0;
        expect_quiet("R10", 4);
    endtask

    task automatic t_hold();
        logic ok = 1'b1;
        int waited = 0;
        reg_write(8'h12, 32'h0000_0071);
        reg_write(8'h13, 32'h0900_0000);
        @(negedge clk); irq_in[1] = 1'b1;
        while (!msg_valid && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!msg_valid || msg_vector != 8'h71 || msg_dest != 8'h09) ok = 1'b0;
        end
        check("R11", "held under backpressure", {31'b0, ok}, 32'h1);
        pop_expect("R11", 8'h71, 8'h09, 1'b0);
        @(negedge clk); irq_in[1] = 1'b0;
    endtask

    task automatic t_unimpl();
        logic [31:0] d;
        reg_write(8'h40, 32'hFFFF_FFFF);
        reg_write(8'h05, 32'hFFFF_FFFF);
        reg_read(8'h40, d);  check("R12", "index 0x40", d, 32'h0);
        reg_read(8'h05, d);  check("R12", "index 0x05", d, 32'h0);
        reg_read(8'h3E, d);  check("R12", "line23 low untouched", d, 32'h0001_0000);
        reg_read(8'h3F, d);  check("R12", "line23 high untouched", d, 32'h0);
        reg_read(8'h10, d);  check("R12", "line0 low untouched", d, 32'h0001_0000);
        reg_read(8'h00, d);  check("R12", "id untouched", d, 32'hAB00_0000);
        expect_quiet("R12", 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_id_version();
        t_layout();
        t_edge();
        t_active_low();
        t_level();
        t_mask();
        t_order();
        t_hold();
        t_unimpl();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule